// File: doc/BRIEF.md
# Table-Driven Biphase Mark Line Serializer

This block turns ready-made 64-bit stereo audio frames into a biphase mark coded line signal, one symbol per clock, with the clock running at twice the data bit rate. Frames come in over a valid/ready handshake into a small internal FIFO. The serializer never looks inside a frame. Sample words, subcode and the rewritten preamble positions are all treated as plain data bits, so every position goes through the same encoding path.

Encoding works one byte at a time. A 256-entry table, computed in logic, maps each byte to the 16 symbols it produces when the line level before it was 0. A one-bit level register holds the last symbol sent. When that symbol was 1, the table output is inverted before it is sent. Two encoded bytes form a 32-symbol group, which loads into a shift register that shifts out toward the line. The same serial stream drives every output pin. If no frame is waiting when a new frame must start, the block sends an all-zero frame and flags the underrun. The line level stays continuous across that frame.

Top module: `bmc_byte_serializer`

## Requirements
- R1: Each data bit takes two consecutive symbol clocks. The line toggles at the start of every bit cell, and it toggles again in the middle of the cell only when the bit is 1. A 64-bit frame therefore takes exactly 128 clocks.
- R2: Within a frame, bits are sent from `in_data[0]` up to `in_data[63]`. The first byte sent is `in_data[7:0]` and the last is `in_data[63:56]`. Frames follow one another with no idle symbols between them.
- R3: The line level carries over across byte, group and frame boundaries. The first bit cell of every byte starts by inverting whatever level the previous symbol left on the line. The first symbol after reset is 1.
- R4: `in_ready` is high exactly when fewer than `FIFO_DEPTH` frames are stored. Frames accepted with `in_valid && in_ready` are sent in the order they were accepted, and none is lost.
- R5: A stored frame is taken only at a frame boundary. The first boundary is the first rising edge after reset is released, and each later boundary comes 128 clocks after the previous one. A frame accepted on the same edge as a boundary cannot be taken by that boundary.
- R6: If no frame is stored at a boundary, an all-zero frame is sent. `underrun` is high for that frame's 128 clocks and low during frames taken from the FIFO.
- R7: All `NUM_PINS` bits of `line_out` carry the same value on every clock.
- R8: During reset, `line_out` is all zeros, `underrun` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock, twice the data bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame is offered on `in_data` |
| in_data | input | 64 | Preformatted stereo frame, bit 0 sent first |
| in_ready | output | 1 | The FIFO has room for a frame |
| line_out | output | NUM_PINS | Identical biphase mark coded line outputs |
| underrun | output | 1 | The frame now being sent is a zero fill |

## Verification
The bench builds the block with `NUM_PINS=3` and `FIFO_DEPTH=2`, which puts the pin replication check and the FIFO full and empty edges within reach in a few frames. It sends every byte value from 0 to 255 twice, once in ascending order and once inverted in descending order, so that each table entry is reached with both starting levels. The expected line is computed bit by bit from the rule that every cell starts with a toggle. A long pause in the input forces several zero-fill frames in a row, so the bench can check that the line level stays continuous through them and that in-order delivery resumes afterwards.

// File: rtl/bmc_byte_serializer.sv
module bmc_byte_serializer #(
  parameter int NUM_PINS   = 2,
  parameter int FIFO_DEPTH = 4
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [63:0]         in_data,
  output logic                in_ready,
  output logic [NUM_PINS-1:0] line_out,
  output logic                underrun
);
  localparam int AW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  function automatic logic [15:0] enc_byte(input logic [7:0] b);
    logic [15:0] s;
    logic lv;
    lv = 1'b0;
    for (int i = 0; i < 8; i++) begin
      lv = ~lv;
      s[2*i] = lv;
      if (b[i]) lv = ~lv;
      s[2*i+1] = lv;
    end
    return s;
  endfunction

  logic [15:0] sym_rom [256];
  for (genvar g = 0; g < 256; g++) begin : g_rom
    assign sym_rom[g] = enc_byte(8'(g));
  end

  logic [63:0]   mem [FIFO_DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] fifo_cnt;
  logic [63:0]   frame_q;
  logic [1:0]    pair_q;
  logic [4:0]    cnt_q;
  logic [31:0]   sr_q;
  logic          lvl_q, underrun_q;

  wire load  = (cnt_q == 5'd31);
  wire start = load && (pair_q == 2'd0);
  wire have  = (fifo_cnt != '0);
  wire push  = in_valid && in_ready;
  wire pop   = start && have;

  wire [63:0] src       = start ? (have ? mem[rd_ptr] : 64'd0) : frame_q;
  wire [15:0] pair_bits = src[{pair_q, 4'b0000} +: 16];
  wire [15:0] e_lo      = sym_rom[pair_bits[7:0]]  ^ {16{lvl_q}};
  wire [15:0] e_hi      = sym_rom[pair_bits[15:8]] ^ {16{e_lo[15]}};

  assign in_ready = (fifo_cnt != CW'(FIFO_DEPTH));
  assign line_out = {NUM_PINS{sr_q[0]}};
  assign underrun = underrun_q;

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr     <= '0;
      wr_ptr     <= '0;
      fifo_cnt   <= '0;
      frame_q    <= '0;
      pair_q     <= '0;
      cnt_q      <= 5'd31;
      sr_q       <= '0;
      lvl_q      <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(FIFO_DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(FIFO_DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      fifo_cnt <= fifo_cnt + CW'(push) - CW'(pop);
      cnt_q    <= cnt_q + 1'b1;
      if (load) begin
        sr_q   <= {e_hi, e_lo};
        lvl_q  <= e_hi[15];
        pair_q <= pair_q + 1'b1;
      end else begin
        sr_q <= {1'b0, sr_q[31:1]};
      end
      if (start) begin
        frame_q    <= src;
        underrun_q <= !have;
      end
    end
  end

  p_cell_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[0] == 1'b0) |-> (sr_q[0] != $past(sr_q[0])));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(FIFO_DEPTH));

  p_pop_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt < $past(fifo_cnt)) |-> $past(start));

  p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !have) |=> underrun_q);

  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(underrun_q));
endmodule

// File: tb/sim_bmc_byte_serializer.sv
module sim_bmc_byte_serializer;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NP   = 3;
  localparam int FD   = 2;
  localparam int NFR  = 67;
  localparam int NCYC = 11000;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [63:0] in_data = '0;
  wire in_ready, underrun;
  wire [NP-1:0] line_out;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bmc_byte_serializer #(.NUM_PINS(NP), .FIFO_DEPTH(FD)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .line_out(line_out), .underrun(underrun));

  function automatic logic [63:0] frame_of(int i);
    logic [63:0] f;
    f = '0;
    if (i < 32)      for (int b = 0; b < 8; b++) f[8*b +: 8] = 8'(8*i + b);
    else if (i < 64) for (int b = 0; b < 8; b++) f[8*b +: 8] = ~8'(8*(i-32) + (7-b));
    else if (i == 64) f = '0;
    else if (i == 65) f = '1;
    else f = 64'hA5A5_0F0F_3C3C_FF00;
    return f;
  endfunction

  function automatic logic [127:0] bmc(logic [63:0] f, logic s);
    logic [127:0] o;
    logic l;
    l = s;
    for (int j = 0; j < 64; j++) begin
      l = ~l;
      o[2*j] = l;
      if (f[j]) l = ~l;
      o[2*j+1] = l;
    end
    return o;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] q [$];
    logic [63:0] f;
    logic [127:0] exp_f;
    int idx;
    logic lvl, exp_un;
    idx = 0; lvl = 1'b0; exp_un = 1'b0; exp_f = '0;
    repeat (4) @(posedge clk);
    #2;
    check(line_out == '0, "R8 line", 128'(line_out), 0);
    check(underrun == 1'b0, "R8 underrun", 128'(underrun), 0);
    check(in_ready == 1'b1, "R8 ready", 128'(in_ready), 1);
    @(negedge clk) rst_n = 1'b1;
    for (int k = 0; k < NCYC; k++) begin
      in_valid = (idx < NFR) && !(k >= 5000 && k < 5700);
      in_data  = frame_of(idx);
      #1;
      check(in_ready == (q.size() < FD), "R4 R5 ready", 128'(in_ready), 128'(q.size() < FD));
      if (k % 128 == 0) begin
        if (q.size() > 0) begin f = q.pop_front(); exp_un = 1'b0; end
        else begin f = '0; exp_un = 1'b1; end
        exp_f = bmc(f, lvl);
        lvl = exp_f[127];
      end
      if (in_valid && in_ready) begin
        q.push_back(in_data);
        idx++;
      end
      @(posedge clk);
      #2;
      check(line_out[0] == exp_f[k % 128], exp_un ? "R6 R1 R3 zero frame symbol" : "R1 R2 R3 symbol",
            128'(line_out[0]), 128'(exp_f[k % 128]));
      check(line_out == {NP{line_out[0]}}, "R7 pins", 128'(line_out), 128'({NP{line_out[0]}}));
      check(underrun == exp_un, "R6 flag", 128'(underrun), 128'(exp_un));
      @(negedge clk);
    end
    check(idx == NFR, "R4 all frames accepted", 128'(idx), 128'(NFR));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule